// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM from a three-wire serial audio link (bit clock, frame clock, data line) and turns each frame into one 18-bit left sample and one 18-bit right sample in the system clock domain. A faster system clock samples all three serial inputs through a synchronizer. Only a rising bit-clock edge, found in the synchronized copy, moves the receiver. A 2-bit format code chooses how a sample sits inside each half-frame: justified to the end at 16 or 18 bits, justified to the start at 18 bits, or I2S-style with a one-bit delay after the frame clock edge.

The receiver makes no assumption about the number of bit clocks in a half-frame. The frame clock transition that ends a half-frame is the moment that half-frame's sample is taken. A half-frame with fewer bit clocks than its format allows still produces a sample. That sample is flagged as not good, and a sticky error bit is set. An active-low power-down input clears the block. After release, no sample pair is reported until a complete frame has been seen.

Top module: `audio_serial_rx`

## Requirements
- R1: With format code 00, each channel's sample is the final 16 bits received before the frame clock changes, MSB first. It is output as an 18-bit value with those 16 bits in the upper part and two zero bits below.
- R2: With format code 01, each channel's sample is the final 18 bits received before the frame clock changes, MSB first.
- R3: With format code 10, each channel's sample is the first 18 bits received after the frame clock changes, MSB first. Later bits in that half-frame do not affect it.
- R4: With format code 11, the first bit after a frame clock change is skipped. The next 18 bits form the sample, MSB first.
- R5: For codes 00, 01 and 10, a half-frame with the frame clock high carries the left channel. For code 11, a half-frame with the frame clock low carries the left channel.
- R6: Data is taken only on rising bit-clock edges. Filler bits outside the sample window do not change the output, whatever the half-frame length.
- R7: After a right half-frame ends, `smp_stb` is high for exactly one system clock. In that cycle `left_smp` and `right_smp` show the pair. The strobe comes three system clocks after the bit-clock rise that carries the first bit of the following half-frame.
- R8: A half-frame is short if it has fewer than 16 bit clocks (code 00) or fewer than 18 (other codes). A short half-frame sets `frame_err`, which stays set until power-down or reset. The pair containing a short half-frame is still strobed, with `smp_good` low. Otherwise `smp_good` is high.
- R9: While `pwr_dn_n` is low, no strobe is issued and `frame_err` is clear. After release, the half-frame that was in progress is dropped. The first strobe reports a left and right half-frame that both started after release.
- R10: After reset, `left_smp`, `right_smp`, `smp_stb`, `smp_good` and `frame_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Synchronous active-low power-down; clears all state |
| fmt_sel | input | 2 | Framing code: 00, 01, 10, 11 as in R1 to R4 |
| bclk_in | input | 1 | Serial bit clock |
| fclk_in | input | 1 | Serial frame (channel) clock |
| sdata_in | input | 1 | Serial data, two's complement, MSB first |
| left_smp | output | 18 | Left sample of the last reported pair |
| right_smp | output | 18 | Right sample of the last reported pair |
| smp_stb | output | 1 | One-cycle pulse marking a new pair |
| smp_good | output | 1 | High when neither half of the reported pair was short |
| frame_err | output | 1 | Sticky short-half-frame flag |

## Verification
Each format is driven at the shortest half-frame its code allows and at longer ones. These lengths tell correct end-justified capture apart from capture at a fixed bit position. The filler bits are inverted between runs, so leakage of don't-care bits shows up as a changed sample. The I2S runs check the inverted channel polarity and the skipped leading bit. A deliberately short half-frame and a power-down cycle followed by a frame with a partial start check the error and suppression behaviour.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  typedef enum logic [1:0] {
    FMT_LSB16 = 2'b00,
    FMT_LSB18 = 2'b01,
    FMT_MSB18 = 2'b10,
    FMT_I2S   = 2'b11
  } fmt_e;

  localparam int unsigned SMP_W   = 18;
  localparam int unsigned SHORT_W = 16;

  // one finished half-frame, handed from the deserializer to the pairing stage
  typedef struct packed {
    logic             left;
    logic             short_hf;
    logic             whole;
    logic [SMP_W-1:0] data;
  } half_t;

endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned TOTAL = WIDTH * STAGES;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (!clr_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign dout = chain_q[STAGES-1];

  initial begin
    if (STAGES < 2 || TOTAL < 2) $error("asrx_sync needs at least two stages");
  end

endmodule

// File: rtl/asrx_deser.sv
module asrx_deser
  import asrx_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_n,
  input  fmt_e  fmt,
  input  logic  bit_stb,
  input  logic  lr_lvl,
  input  logic  sd_bit,
  output logic  hf_done,
  output half_t hf
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WORD_END = CNT_W'(SMP_W);
  localparam logic [CNT_W-1:0] MIN_SHRT = CNT_W'(SHORT_W);

  logic             known_q, known_d;
  logic             lr_q, lr_d;
  logic             whole_q, whole_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SMP_W-1:0] shreg_q, shreg_d;

  logic             boundary;
  logic             sh_en;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] min_len;
  logic [SMP_W-1:0] base;

  always_comb begin
    boundary = bit_stb && known_q && (lr_lvl != lr_q);
    idx      = boundary ? '0 : cnt_q;
    case (fmt)
      FMT_MSB18: sh_en = (idx < WORD_END);
      FMT_I2S:   sh_en = (idx != '0) && (idx <= WORD_END);
      default:   sh_en = 1'b1;
    endcase
    base    = boundary ? '0 : shreg_q;
    known_d = 1'b1;
    lr_d    = lr_lvl;
    whole_d = whole_q | boundary;
    if (!known_q) begin
      cnt_d   = CNT_ONE;
      shreg_d = shreg_q;
    end else begin
      if (boundary)              cnt_d = CNT_ONE;
      else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
      else                       cnt_d = cnt_q + CNT_ONE;
      shreg_d = sh_en ? {base[SMP_W-2:0], sd_bit} : base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      known_q <= 1'b0;
      lr_q    <= 1'b0;
      whole_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (!clr_n) begin
      known_q <= 1'b0;
      lr_q    <= 1'b0;
      whole_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (bit_stb) begin
      known_q <= known_d;
      lr_q    <= lr_d;
      whole_q <= whole_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
    end
  end

  always_comb begin
    min_len     = (fmt == FMT_LSB16) ? MIN_SHRT : WORD_END;
    hf_done     = boundary;
    hf.left     = lr_q ^ (fmt == FMT_I2S);
    hf.short_hf = (cnt_q < min_len);
    hf.whole    = whole_q;
    if (fmt == FMT_LSB16) hf.data = {shreg_q[SHORT_W-1:0], {(SMP_W-SHORT_W){1'b0}}};
    else                  hf.data = shreg_q;
  end

endmodule

// File: rtl/asrx_pair.sv
module asrx_pair
  import asrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             hf_done,
  input  half_t            hf,
  output logic [SMP_W-1:0] left_smp,
  output logic [SMP_W-1:0] right_smp,
  output logic             smp_stb,
  output logic             smp_good,
  output logic             frame_err
);

  logic [SMP_W-1:0] hold_q, hold_d;
  logic             pend_q, pend_d;
  logic             lbad_q, lbad_d;
  logic [SMP_W-1:0] left_d, right_d;
  logic             stb_d, good_d, err_d;
  logic             take;

  always_comb begin
    take    = hf_done && hf.whole;
    hold_d  = hold_q;
    pend_d  = pend_q;
    lbad_d  = lbad_q;
    left_d  = left_smp;
    right_d = right_smp;
    stb_d   = 1'b0;
    good_d  = smp_good;
    err_d   = frame_err | (take && hf.short_hf);
    if (take) begin
      if (hf.left) begin
        hold_d = hf.data;
        pend_d = 1'b1;
        lbad_d = hf.short_hf;
      end else if (pend_q) begin
        left_d  = hold_q;
        right_d = hf.data;
        stb_d   = 1'b1;
        good_d  = !(lbad_q || hf.short_hf);
        pend_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      pend_q    <= 1'b0;
      lbad_q    <= 1'b0;
      left_smp  <= '0;
      right_smp <= '0;
      smp_stb   <= 1'b0;
      smp_good  <= 1'b0;
      frame_err <= 1'b0;
    end else if (!clr_n) begin
      hold_q    <= '0;
      pend_q    <= 1'b0;
      lbad_q    <= 1'b0;
      left_smp  <= '0;
      right_smp <= '0;
      smp_stb   <= 1'b0;
      smp_good  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      hold_q    <= hold_d;
      pend_q    <= pend_d;
      lbad_q    <= lbad_d;
      left_smp  <= left_d;
      right_smp <= right_d;
      smp_stb   <= stb_d;
      smp_good  <= good_d;
      frame_err <= err_d;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && clr_n) |=> frame_err);

  // R8
  short_raises_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && hf_done && hf.whole && hf.short_hf) |=> frame_err);

  // R9
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (!smp_stb && !frame_err));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_dn_n,
  input  logic [1:0]  fmt_sel,
  input  logic        bclk_in,
  input  logic        fclk_in,
  input  logic        sdata_in,
  output logic [17:0] left_smp,
  output logic [17:0] right_smp,
  output logic        smp_stb,
  output logic        smp_good,
  output logic        frame_err
);

  localparam int unsigned PINS = 3;

  logic [PINS-1:0] pins_raw, pins_sync;
  logic            bclk_dly_q, bclk_dly_d;
  logic            bit_stb;
  logic            hf_done;
  half_t           hf;

  assign pins_raw = {sdata_in, fclk_in, bclk_in};

  asrx_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (pwr_dn_n),
    .din   (pins_raw),
    .dout  (pins_sync)
  );

  always_comb begin
    bclk_dly_d = pins_sync[0];
    bit_stb    = pins_sync[0] && !bclk_dly_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bclk_dly_q <= 1'b0;
    else if (!pwr_dn_n) bclk_dly_q <= 1'b0;
    else                bclk_dly_q <= bclk_dly_d;
  end

  asrx_deser #(.CNT_W(CNT_W)) u_deser (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (pwr_dn_n),
    .fmt     (fmt_e'(fmt_sel)),
    .bit_stb (bit_stb),
    .lr_lvl  (pins_sync[1]),
    .sd_bit  (pins_sync[2]),
    .hf_done (hf_done),
    .hf      (hf)
  );

  asrx_pair u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (pwr_dn_n),
    .hf_done   (hf_done),
    .hf        (hf),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .smp_stb   (smp_stb),
    .smp_good  (smp_good),
    .frame_err (frame_err)
  );

  // R7
  stb_follows_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> $past(hf_done));

  // R6
  half_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hf_done |=> !hf_done);

endmodule

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;

  logic        clk = 1'b0;
  logic        rst_n, pwr_dn_n;
  logic [1:0]  fmt_sel;
  logic        bclk_in, fclk_in, sdata_in;
  logic [17:0] left_smp, right_smp;
  logic        smp_stb, smp_good, frame_err;

  always #10 clk = ~clk;

  audio_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .fmt_sel(fmt_sel),
    .bclk_in(bclk_in), .fclk_in(fclk_in), .sdata_in(sdata_in),
    .left_smp(left_smp), .right_smp(right_smp), .smp_stb(smp_stb),
    .smp_good(smp_good), .frame_err(frame_err)
  );

  typedef struct {
    int          due;
    logic [17:0] l;
    logic [17:0] r;
    logic        g;
  } exp_t;

  exp_t        expq[$];
  bit          bitsq[$];
  int          tcount = 0, n_chk = 0, n_fail = 0, stb_seen = 0;
  bit          done = 0;
  int          m_mode = 0, m_err_at = -1;
  bit          m_known = 0, m_whole = 0, m_lr = 0, m_lpend = 0, m_lbad = 0;
  logic [17:0] m_lhold = '0;

  function automatic string tag_of(int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (tick %0d)", tag, act, exp, tcount);
    end
  endtask

  function automatic logic [17:0] half_value(int mode);
    logic [17:0] v = '0;
    int n = bitsq.size();
    case (mode)
      0: begin
        for (int i = (n > 16 ? n - 16 : 0); i < n; i++) v = {v[16:0], bitsq[i]};
        v = v << 2;
      end
      1: for (int i = (n > 18 ? n - 18 : 0); i < n; i++) v = {v[16:0], bitsq[i]};
      2: for (int i = 0; i < 18 && i < n; i++) v = {v[16:0], bitsq[i]};
      default: for (int i = 1; i < 19 && i < n; i++) v = {v[16:0], bitsq[i]};
    endcase
    return v;
  endfunction

  task automatic finish_half(bit lrp);
    logic [17:0] v;
    bit sh, is_left;
    if (!m_whole) return;
    is_left = (m_mode == 3) ? !lrp : lrp;
    v  = half_value(m_mode);
    sh = bitsq.size() < ((m_mode == 0) ? 16 : 18);
    if (sh && m_err_at < 0) m_err_at = tcount + 3;
    if (is_left) begin
      m_lhold = v; m_lpend = 1; m_lbad = sh;
    end else if (m_lpend) begin
      expq.push_back('{tcount + 3, m_lhold, v, !(m_lbad || sh)});
      m_lpend = 0;
    end
  endtask

  task automatic model_bit(bit lr, bit b);
    if (!m_known) begin
      m_known = 1; m_lr = lr; bitsq.delete(); bitsq.push_back(b);
      return;
    end
    if (lr != m_lr) begin
      finish_half(m_lr);
      bitsq.delete();
      m_whole = 1;
      m_lr = lr;
    end
    bitsq.push_back(b);
  endtask

  task automatic observe();
    bit es;
    es = (expq.size() > 0) && (expq[0].due == tcount);
    chk("R7 strobe", smp_stb, es);
    if (smp_stb) stb_seen++;
    if (es) begin
      chk({tag_of(m_mode), " left sample"}, left_smp, expq[0].l);
      chk({tag_of(m_mode), " right sample"}, right_smp, expq[0].r);
      chk("R8 good flag", smp_good, expq[0].g);
      void'(expq.pop_front());
    end
    chk("R8 error flag", frame_err, (m_err_at >= 0 && tcount >= m_err_at));
  endtask

  task automatic tick(logic b, logic f, logic d);
    bit rising;
    @(negedge clk);
    tcount++;
    observe();
    rising = b && !bclk_in && rst_n && pwr_dn_n;
    bclk_in = b; fclk_in = f; sdata_in = d;
    if (rising) model_bit(f, d);
  endtask

  task automatic idle(int n);
    repeat (n) tick(1'b0, fclk_in, 1'b0);
  endtask

  task automatic set_pd(bit v);
    @(negedge clk);
    tcount++;
    observe();
    pwr_dn_n = v;
    if (!v) begin
      m_known = 0; m_whole = 0; m_lpend = 0; m_err_at = -1;
      bitsq.delete();
    end
  endtask

  task automatic set_mode(int m);
    idle(8);
    set_pd(1'b0);
    idle(3);
    chk("R9 left cleared in power-down", left_smp, 18'h0);
    chk("R9 strobe low in power-down", smp_stb, 1'b0);
    fmt_sel = m[1:0];
    m_mode = m;
    set_pd(1'b1);
    idle(4);
  endtask

  task automatic send_half(bit lr, int n, logic [17:0] v, bit inv);
    for (int i = 0; i < n; i++) begin
      bit b;
      int pos;
      b = ((i % 3) == 0) ^ inv;
      case (m_mode)
        0: begin pos = i - (n - 16); if (pos >= 0) b = v[15 - pos]; end
        1: begin pos = i - (n - 18); if (pos >= 0) b = v[17 - pos]; end
        2: if (i < 18) b = v[17 - i];
        default: if (i >= 1 && i < 19) b = v[18 - i];
      endcase
      repeat (2) tick(1'b0, lr, b);
      repeat (2) tick(1'b1, lr, b);
    end
  endtask

  function automatic bit left_lvl();
    return (m_mode == 3) ? 1'b0 : 1'b1;
  endfunction

  task automatic send_frame(logic [17:0] lv, logic [17:0] rv, int n, bit inv);
    send_half(left_lvl(), n, lv, inv);
    send_half(!left_lvl(), n, rv, inv);
  endtask

  task automatic lead_in();
    send_half(!left_lvl(), 3, 18'h0, 1'b0);
  endtask

  task automatic flush();
    send_half(left_lvl(), 20, 18'h0, 1'b0);
    idle(8);
  endtask

  initial begin
    int base;
    rst_n = 1'b0; pwr_dn_n = 1'b1; fmt_sel = 2'b00;
    bclk_in = 1'b0; fclk_in = 1'b0; sdata_in = 1'b0;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10 left after reset", left_smp, 18'h0);
    chk("R10 right after reset", right_smp, 18'h0);
    chk("R10 strobe after reset", smp_stb, 1'b0);
    chk("R10 good after reset", smp_good, 1'b0);
    chk("R10 error after reset", frame_err, 1'b0);
    rst_n = 1'b1;
    idle(4);

    // R1, R5, R6: 16-bit end-justified at several half-frame lengths
    set_mode(0);
    lead_in();
    send_frame(18'h0A5C3, 18'h05A3C, 16, 1'b0);
    send_frame(18'h08000, 18'h07FFF, 24, 1'b0);
    send_frame(18'h01234, 18'h0FEDC, 32, 1'b1);
    flush();
    chk("R1 R5 left of last pair", left_smp, 18'h048D0);
    chk("R1 right of last pair", right_smp, 18'h3FB70);

    // R2, R6: 18-bit end-justified
    set_mode(1);
    lead_in();
    send_frame(18'h2AAAA, 18'h15555, 18, 1'b0);
    send_frame(18'h20001, 18'h1FFFE, 32, 1'b1);
    flush();
    chk("R2 left of last pair", left_smp, 18'h20001);
    chk("R6 right ignores filler", right_smp, 18'h1FFFE);

    // R3: start-justified, 16-bit source padded with zeros
    set_mode(2);
    lead_in();
    send_frame(18'h3C0F0, 18'h03F0F, 18, 1'b0);
    send_frame(18'h12340, 18'h2BCD0, 30, 1'b1);
    flush();
    chk("R3 left of last pair", left_smp, 18'h12340);
    chk("R3 right of last pair", right_smp, 18'h2BCD0);

    // R4, R5: one-bit delay, inverted channel polarity
    set_mode(3);
    lead_in();
    send_frame(18'h25A5A, 18'h1A5A5, 20, 1'b0);
    send_frame(18'h30003, 18'h0FFF0, 32, 1'b1);
    flush();
    chk("R4 R5 left on low frame clock", left_smp, 18'h30003);
    chk("R4 right on high frame clock", right_smp, 18'h0FFF0);

    // R8: short half-frame
    set_mode(0);
    lead_in();
    send_frame(18'h0F00F, 18'h00FF0, 12, 1'b0);
    send_frame(18'h00001, 18'h0FFFF, 16, 1'b0);
    flush();
    chk("R8 error stays set", frame_err, 1'b1);
    chk("R8 later full frame is good", smp_good, 1'b1);

    // R9: power-down clears, partial first frame suppressed
    set_mode(0);
    chk("R9 error cleared", frame_err, 1'b0);
    base = stb_seen;
    send_frame(18'h01111, 18'h02222, 16, 1'b0);
    send_frame(18'h03333, 18'h04444, 16, 1'b0);
    flush();
    chk("R9 one strobe after release", stb_seen - base, 1);
    chk("R9 reported pair is the complete frame", left_smp, 18'h0CCCC);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule